// File: doc/BRIEF.md
# Oscillator Fault Fail-Safe Controller

This block collects fault indications from three clock sources: a low-frequency crystal, a high-frequency crystal, and a resistor-trimmed DCO, which can report either an open fault or a short fault. Each fault sets a sticky flag. Software clears the flag with a dedicated strobe. Three of the flags, each qualified by its own enable, merge into a single request line that feeds the shared non-maskable or maskable interrupt path.

The block also acts as a fail-safe. While a crystal's flag is set, every system clock whose software select field names that crystal is redirected to a backup oscillator:

- Low-frequency crystal faults move the affected clocks to the internal reference oscillator. This applies to all six clock outputs in every power mode.
- High-frequency crystal faults move only the main and the two sub-main clocks to the system oscillator.
- High-frequency faults are ignored in low-power modes.

The software select fields are never written. Only the effective select driven out changes. While the reference oscillator stands in for a failed low-frequency crystal, its frequency select is forced to the 32.768 kHz setting.

Each flag is a two-state machine:

- `ST_CLEAR` moves to `ST_LATCHED` on a synchronized set.
- `ST_LATCHED` moves back to `ST_CLEAR` on a clear with no concurrent set.
- In every other case the state holds.

Fault inputs pass through a two-flop synchronizer before they reach the flags.

Top module: `osc_failsafe_ctrl`

Clock index order in `sel_i` and `eff_sel_o`:

| Index | Clock |
|---|---|
| 0 | auxiliary |
| 1 | backup |
| 2 | main |
| 3 | high-speed sub-main |
| 4 | low-speed sub-main |
| 5 | raw LF output |

Clock `i` occupies bits `[3*i+2:3*i]`.

Source codes:

| Code | Source |
|---|---|
| 0 | LF crystal |
| 1 | low-power RC |
| 2 | reference oscillator |
| 3 | DCO |
| 4 | module RC |
| 5 | HF crystal |
| 6 | system oscillator |

## Requirements
- R1: While `por_n` is low, all four flags and `irq_o` are 0, `eff_sel_o` equals `sel_i`, and fault strobes have no effect.
- R2: A fault input high before rising edge n sets its flag, visible after edge n+2. There is one edge of delay for each synchronizer flop and one for the flag.
- R3: A clear strobe high before an edge clears its flag at that edge, unless the synchronized fault of the same flag is set at that edge, in which case the flag is set (set wins).
- R4: The DCO short flag is cleared only by `dco_short_rst_clr_i` or by reset. The other clear strobes leave it set, and it never drives `irq_o`.
- R5: `irq_o` = (LF flag & `lf_ie_i`) | (HF flag & `hf_ie_i`) | (DCO open flag & `dco_open_ie_i`), combinationally in the same cycle.
- R6: While the LF flag is set, every clock (indices 0 to 5) whose select is 0 (LF crystal) shows 2 (reference oscillator) on `eff_sel_o`. Other clocks are unchanged.
- R7: While the HF flag is set, clocks 2, 3 and 4 whose select is 5 (HF crystal) show 6 (system oscillator). Clocks 0, 1 and 5 selecting 5 stay at 5.
- R8: When `lpm_i` is high at the flag-sampling edge, a synchronized HF fault does not set the HF flag. LF and DCO faults still set their flags.
- R9: After the flag clears, `eff_sel_o` returns to `sel_i` in the same cycle. No software select value is altered by an override.
- R10: `refo_fsel_eff_o` is 0 (32.768 kHz) while any clock is redirected by R6. Otherwise it equals `refo_fsel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| lf_fault_i | input | 1 | LF crystal fault indication |
| hf_fault_i | input | 1 | HF crystal fault indication |
| dco_open_fault_i | input | 1 | DCO resistor open fault |
| dco_short_fault_i | input | 1 | DCO resistor short fault |
| lf_clr_i | input | 1 | Software clear of LF flag |
| hf_clr_i | input | 1 | Software clear of HF flag |
| dco_open_clr_i | input | 1 | Software clear of DCO open flag |
| dco_short_rst_clr_i | input | 1 | Reset-controller clear of DCO short flag |
| lf_ie_i | input | 1 | LF interrupt enable |
| hf_ie_i | input | 1 | HF interrupt enable |
| dco_open_ie_i | input | 1 | DCO open interrupt enable |
| lpm_i | input | 1 | High in a low-power mode |
| refo_fsel_i | input | 1 | Software frequency select of reference oscillator |
| sel_i | input | 18 | Software source select, 3 bits per clock |
| lf_flag_o | output | 1 | LF fault flag |
| hf_flag_o | output | 1 | HF fault flag |
| dco_open_flag_o | output | 1 | DCO open fault flag |
| dco_short_flag_o | output | 1 | DCO short fault flag |
| irq_o | output | 1 | Shared interrupt request |
| eff_sel_o | output | 18 | Effective source per clock |
| refo_fsel_eff_o | output | 1 | Effective reference oscillator frequency select |

## Verification
Flag results are due two rising edges after the edge that first samples a fault input. A clear result is due at the first edge after the strobe. `irq_o`, `eff_sel_o` and `refo_fsel_eff_o` follow their inputs and the flags within the same cycle. The bench updates its reference model at each rising edge from the inputs held across that edge. It changes inputs and compares every output at the falling edge, so each latency is checked in exactly the cycle it is due.

// File: rtl/osc_fs_pkg.sv
package osc_fs_pkg;
    localparam int SRC_W = 3;
    localparam int NFLT  = 4;
    localparam int FLT_LF     = 0;
    localparam int FLT_HF     = 1;
    localparam int FLT_DOPEN  = 2;
    localparam int FLT_DSHORT = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_LFX    = 3'd0,
        SRC_LOWRC  = 3'd1,
        SRC_REFOSC = 3'd2,
        SRC_DCO    = 3'd3,
        SRC_MODRC  = 3'd4,
        SRC_HFX    = 3'd5,
        SRC_SYSRC  = 3'd6,
        SRC_RSVD   = 3'd7
    } clk_src_e;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_LATCHED = 1'b1
    } latch_st_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/fault_latch.sv
module fault_latch
    import osc_fs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    latch_st_e state_q;
    latch_st_e state_d;

    // next state: set has priority over clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (set_i) state_d = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (clr_i && !set_i) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAR:   flag_o = 1'b0;
            ST_LATCHED: flag_o = 1'b1;
            default:    flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/src_override.sv
module src_override
    import osc_fs_pkg::*;
#(
    parameter int                   NUM_CLK = 6,
    parameter logic [NUM_CLK-1:0]   HF_MASK = 6'b011100,
    localparam int                  BUS_W   = NUM_CLK * SRC_W
) (
    input  logic [BUS_W-1:0] sel_i,
    input  logic             lf_flag_i,
    input  logic             hf_flag_i,
    output logic [BUS_W-1:0] eff_o,
    output logic             lf_hit_o
);
    logic [NUM_CLK-1:0] lf_hit;

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
        logic [SRC_W-1:0] sw_sel;
        assign sw_sel = sel_i[i*SRC_W +: SRC_W];
        assign lf_hit[i] = lf_flag_i && (sw_sel == SRC_LFX);

        if (HF_MASK[i]) begin : g_hf_covered
            always_comb begin
                if (lf_hit[i])
                    eff_o[i*SRC_W +: SRC_W] = SRC_REFOSC;
                else if (hf_flag_i && (sw_sel == SRC_HFX))
                    eff_o[i*SRC_W +: SRC_W] = SRC_SYSRC;
                else
                    eff_o[i*SRC_W +: SRC_W] = sw_sel;
            end
        end else begin : g_lf_only
            always_comb begin
                if (lf_hit[i])
                    eff_o[i*SRC_W +: SRC_W] = SRC_REFOSC;
                else
                    eff_o[i*SRC_W +: SRC_W] = sw_sel;
            end
        end
    end

    assign lf_hit_o = |lf_hit;
endmodule

// File: rtl/osc_failsafe_ctrl.sv
module osc_failsafe_ctrl
    import osc_fs_pkg::*;
#(
    parameter int                   NUM_CLK = 6,
    parameter logic [NUM_CLK-1:0]   HF_MASK = 6'b011100,
    localparam int                  BUS_W   = NUM_CLK * SRC_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             lf_fault_i,
    input  logic             hf_fault_i,
    input  logic             dco_open_fault_i,
    input  logic             dco_short_fault_i,
    input  logic             lf_clr_i,
    input  logic             hf_clr_i,
    input  logic             dco_open_clr_i,
    input  logic             dco_short_rst_clr_i,
    input  logic             lf_ie_i,
    input  logic             hf_ie_i,
    input  logic             dco_open_ie_i,
    input  logic             lpm_i,
    input  logic             refo_fsel_i,
    input  logic [BUS_W-1:0] sel_i,
    output logic             lf_flag_o,
    output logic             hf_flag_o,
    output logic             dco_open_flag_o,
    output logic             dco_short_flag_o,
    output logic             irq_o,
    output logic [BUS_W-1:0] eff_sel_o,
    output logic             refo_fsel_eff_o
);
    logic [NFLT-1:0] flt_raw;
    logic [NFLT-1:0] flt_sync;
    logic [NFLT-1:0] flt_set;
    logic [NFLT-1:0] flt_clr;
    logic [NFLT-1:0] flt_flag;
    logic            lf_redirect;

    assign flt_raw[FLT_LF]     = lf_fault_i;
    assign flt_raw[FLT_HF]     = hf_fault_i;
    assign flt_raw[FLT_DOPEN]  = dco_open_fault_i;
    assign flt_raw[FLT_DSHORT] = dco_short_fault_i;

    fault_sync #(.W(NFLT)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i (flt_raw),
        .sync_o  (flt_sync)
    );

    // HF fault handling is suspended in low-power modes
    assign flt_set[FLT_LF]     = flt_sync[FLT_LF];
    assign flt_set[FLT_HF]     = flt_sync[FLT_HF] && !lpm_i;
    assign flt_set[FLT_DOPEN]  = flt_sync[FLT_DOPEN];
    assign flt_set[FLT_DSHORT] = flt_sync[FLT_DSHORT];

    assign flt_clr[FLT_LF]     = lf_clr_i;
    assign flt_clr[FLT_HF]     = hf_clr_i;
    assign flt_clr[FLT_DOPEN]  = dco_open_clr_i;
    assign flt_clr[FLT_DSHORT] = dco_short_rst_clr_i;

    for (genvar f = 0; f < NFLT; f++) begin : g_flag
        fault_latch u_latch (
            .clk    (clk),
            .rst_n  (por_n),
            .set_i  (flt_set[f]),
            .clr_i  (flt_clr[f]),
            .flag_o (flt_flag[f])
        );
    end

    assign lf_flag_o        = flt_flag[FLT_LF];
    assign hf_flag_o        = flt_flag[FLT_HF];
    assign dco_open_flag_o  = flt_flag[FLT_DOPEN];
    assign dco_short_flag_o = flt_flag[FLT_DSHORT];

    assign irq_o = (flt_flag[FLT_LF]    && lf_ie_i)
                || (flt_flag[FLT_HF]    && hf_ie_i)
                || (flt_flag[FLT_DOPEN] && dco_open_ie_i);

    src_override #(
        .NUM_CLK (NUM_CLK),
        .HF_MASK (HF_MASK)
    ) u_ovr (
        .sel_i     (sel_i),
        .lf_flag_i (flt_flag[FLT_LF]),
        .hf_flag_i (flt_flag[FLT_HF]),
        .eff_o     (eff_sel_o),
        .lf_hit_o  (lf_redirect)
    );

    // fail-safe reference oscillator always runs at the 32.768 kHz setting
    assign refo_fsel_eff_o = lf_redirect ? 1'b0 : refo_fsel_i;
endmodule

// File: rtl/osc_failsafe_chk.sv
module osc_failsafe_chk
    import osc_fs_pkg::*;
#(
    parameter int                   NUM_CLK = 6,
    parameter logic [NUM_CLK-1:0]   HF_MASK = 6'b011100,
    localparam int                  BUS_W   = NUM_CLK * SRC_W
) (
    input logic             clk,
    input logic             por_n,
    input logic             lf_sync,
    input logic             lf_clr_i,
    input logic             dco_short_rst_clr_i,
    input logic             lpm_i,
    input logic             lf_ie_i,
    input logic             hf_ie_i,
    input logic             dco_open_ie_i,
    input logic             refo_fsel_eff_o,
    input logic             lf_flag_o,
    input logic             hf_flag_o,
    input logic             dco_open_flag_o,
    input logic             dco_short_flag_o,
    input logic             irq_o,
    input logic [BUS_W-1:0] sel_i,
    input logic [BUS_W-1:0] eff_sel_o
);
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        lf_sync |=> lf_flag_o)
        else $error("R3 synchronized LF fault did not set flag");

    a_r3_clear_flag: assert property (@(posedge clk) disable iff (!por_n)
        (lf_clr_i && !lf_sync) |=> !lf_flag_o)
        else $error("R3 LF clear ignored");

    a_r4_short_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (dco_short_flag_o && !dco_short_rst_clr_i) |=> dco_short_flag_o)
        else $error("R4 short flag dropped without its clear");

    a_r5_irq_merge: assert property (@(posedge clk) disable iff (!por_n)
        irq_o == ((lf_flag_o && lf_ie_i) || (hf_flag_o && hf_ie_i)
                  || (dco_open_flag_o && dco_open_ie_i)))
        else $error("R5 request mismatch");

    a_r8_hf_lpm_hold: assert property (@(posedge clk) disable iff (!por_n)
        (lpm_i && !hf_flag_o) |=> !hf_flag_o)
        else $error("R8 HF flag set in low-power mode");

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_chk
        a_r6_lf_redirect: assert property (@(posedge clk) disable iff (!por_n)
            (lf_flag_o && sel_i[i*SRC_W +: SRC_W] == SRC_LFX)
            |-> (eff_sel_o[i*SRC_W +: SRC_W] == SRC_REFOSC && !refo_fsel_eff_o))
            else $error("R6 R10 LF redirect missing on clock %0d", i);

        if (HF_MASK[i]) begin : g_hf
            a_r7_hf_redirect: assert property (@(posedge clk) disable iff (!por_n)
                (hf_flag_o && sel_i[i*SRC_W +: SRC_W] == SRC_HFX)
                |-> eff_sel_o[i*SRC_W +: SRC_W] == SRC_SYSRC)
                else $error("R7 HF redirect missing on clock %0d", i);
        end else begin : g_nohf
            a_r7_hf_untouched: assert property (@(posedge clk) disable iff (!por_n)
                (sel_i[i*SRC_W +: SRC_W] == SRC_HFX)
                |-> eff_sel_o[i*SRC_W +: SRC_W] == SRC_HFX)
                else $error("R7 HF redirect on uncovered clock %0d", i);
        end
    end
endmodule

bind osc_failsafe_ctrl osc_failsafe_chk #(
    .NUM_CLK (NUM_CLK),
    .HF_MASK (HF_MASK)
) u_chk (
    .clk                 (clk),
    .por_n               (por_n),
    .lf_sync             (flt_sync[0]),
    .lf_clr_i            (lf_clr_i),
    .dco_short_rst_clr_i (dco_short_rst_clr_i),
    .lpm_i               (lpm_i),
    .lf_ie_i             (lf_ie_i),
    .hf_ie_i             (hf_ie_i),
    .dco_open_ie_i       (dco_open_ie_i),
    .refo_fsel_eff_o     (refo_fsel_eff_o),
    .lf_flag_o           (lf_flag_o),
    .hf_flag_o           (hf_flag_o),
    .dco_open_flag_o     (dco_open_flag_o),
    .dco_short_flag_o    (dco_short_flag_o),
    .irq_o               (irq_o),
    .sel_i               (sel_i),
    .eff_sel_o           (eff_sel_o)
);

// File: tb/tb_osc_failsafe_ctrl.sv
module tb_osc_failsafe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCLK = 6;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic lf_f = 0, hf_f = 0, do_f = 0, ds_f = 0;
    logic lf_c = 0, hf_c = 0, do_c = 0, ds_c = 0;
    logic lf_ie = 0, hf_ie = 0, do_ie = 0, lpm = 0, refo_fsel = 0;
    logic [NCLK*3-1:0] sel = '0;

    logic lf_fl, hf_fl, do_fl, ds_fl, irq, refo_eff;
    logic [NCLK*3-1:0] eff;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_s1 = '0, m_s2 = '0, m_flag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_failsafe_ctrl dut (
        .clk(clk), .por_n(por_n),
        .lf_fault_i(lf_f), .hf_fault_i(hf_f),
        .dco_open_fault_i(do_f), .dco_short_fault_i(ds_f),
        .lf_clr_i(lf_c), .hf_clr_i(hf_c),
        .dco_open_clr_i(do_c), .dco_short_rst_clr_i(ds_c),
        .lf_ie_i(lf_ie), .hf_ie_i(hf_ie), .dco_open_ie_i(do_ie),
        .lpm_i(lpm), .refo_fsel_i(refo_fsel), .sel_i(sel),
        .lf_flag_o(lf_fl), .hf_flag_o(hf_fl),
        .dco_open_flag_o(do_fl), .dco_short_flag_o(ds_fl),
        .irq_o(irq), .eff_sel_o(eff), .refo_fsel_eff_o(refo_eff)
    );

    function automatic logic [2:0] exp_eff(int i);
        logic [2:0] s = sel[i*3 +: 3];
        if (m_flag[0] && s == 3'd0) return 3'd2;
        if (m_flag[1] && s == 3'd5 && i >= 2 && i <= 4) return 3'd6;
        return s;
    endfunction

    function automatic logic exp_irq();
        return (m_flag[0] & lf_ie) | (m_flag[1] & hf_ie) | (m_flag[2] & do_ie);
    endfunction

    function automatic logic exp_refo();
        for (int i = 0; i < NCLK; i++)
            if (m_flag[0] && sel[i*3 +: 3] == 3'd0) return 1'b0;
        return refo_fsel;
    endfunction

    task automatic model_edge();
        logic [3:0] nf;
        if (!por_n) begin
            m_s1 = '0; m_s2 = '0; m_flag = '0;
        end else begin
            nf[0] = m_s2[0] ? 1'b1 : (lf_c ? 1'b0 : m_flag[0]);
            nf[1] = (m_s2[1] && !lpm) ? 1'b1 : (hf_c ? 1'b0 : m_flag[1]);
            nf[2] = m_s2[2] ? 1'b1 : (do_c ? 1'b0 : m_flag[2]);
            nf[3] = m_s2[3] ? 1'b1 : (ds_c ? 1'b0 : m_flag[3]);
            m_flag = nf;
            m_s2 = m_s1;
            m_s1 = {ds_f, do_f, hf_f, lf_f};
        end
    endtask

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " lf flag"}, lf_fl, m_flag[0]);
        check({tag, " hf flag"}, hf_fl, m_flag[1]);
        check({tag, " dco open flag"}, do_fl, m_flag[2]);
        check({tag, " R4 dco short flag"}, ds_fl, m_flag[3]);
        check("R5 irq", irq, exp_irq());
        for (int i = 0; i < NCLK; i++)
            check($sformatf("R6 R7 R9 eff sel clk%0d", i), eff[i*3 +: 3], exp_eff(i));
        check("R10 refo fsel", refo_eff, exp_refo());
    endtask

    task automatic cyc(string tag, int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_all(tag);
        end
    endtask

    task automatic strobes_off();
        lf_f = 0; hf_f = 0; do_f = 0; ds_f = 0;
        lf_c = 0; hf_c = 0; do_c = 0; ds_c = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C5F_A11E));
        // R1: reset holds flags at zero, faults ignored
        sel = {3'd0, 3'd5, 3'd0, 3'd5, 3'd1, 3'd0};
        lf_ie = 1; hf_ie = 1; do_ie = 1; refo_fsel = 1;
        lf_f = 1; hf_f = 1; ds_f = 1;
        @(negedge clk);
        check_all("R1 reset");
        cyc("R1 reset", 3);
        strobes_off();
        cyc("R1 reset", 2);
        por_n = 1;
        cyc("R1 idle", 3);

        // R2: latency of two synchronizer flops plus flag
        lf_f = 1;
        cyc("R2 latency");
        lf_f = 0;
        cyc("R2 latency", 4);

        // R9: clear returns effective selection
        lf_c = 1;
        cyc("R9 return");
        lf_c = 0;
        cyc("R9 return", 2);

        // R3: set and clear together, set wins
        sel = {3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5};
        hf_f = 1; hf_c = 1;
        cyc("R3 set wins", 4);
        hf_f = 0;
        cyc("R3 set wins", 2);
        hf_c = 0;
        // R7: only main and sub-main clocks redirected
        cyc("R7 hf redirect", 2);
        hf_c = 1;
        cyc("R3 clear");
        hf_c = 0;

        // R4: short flag ignores normal clears
        ds_f = 1;
        cyc("R4 short set");
        ds_f = 0;
        cyc("R4 short set", 3);
        lf_c = 1; hf_c = 1; do_c = 1;
        cyc("R4 other clears", 2);
        strobes_off();
        ds_c = 1;
        cyc("R4 reset clear");
        ds_c = 0;
        cyc("R4 reset clear");

        // R8: HF fault ignored in low-power mode, LF still active
        lpm = 1;
        hf_f = 1; lf_f = 1; do_f = 1;
        cyc("R8 lpm", 2);
        strobes_off();
        cyc("R8 lpm", 4);
        lpm = 0;
        lf_c = 1; do_c = 1;
        cyc("R8 clear");
        strobes_off();

        // random phase: R2 R3 R5 R6 R7 R10
        for (int n = 0; n < 4000; n++) begin
            lf_f = ($urandom_range(0, 15) == 0);
            hf_f = ($urandom_range(0, 15) == 0);
            do_f = ($urandom_range(0, 15) == 0);
            ds_f = ($urandom_range(0, 31) == 0);
            lf_c = ($urandom_range(0, 7) == 0);
            hf_c = ($urandom_range(0, 7) == 0);
            do_c = ($urandom_range(0, 7) == 0);
            ds_c = ($urandom_range(0, 15) == 0);
            lf_ie = 1'($urandom); hf_ie = 1'($urandom); do_ie = 1'($urandom);
            lpm = ($urandom_range(0, 3) == 0);
            refo_fsel = 1'($urandom);
            if ($urandom_range(0, 7) == 0)
                for (int i = 0; i < NCLK; i++)
                    sel[i*3 +: 3] = 3'($urandom_range(0, 7));
            cyc("R2 R3 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule